// File: doc/BRIEF.md
# Serial Command Front End with Write-Enable Guard

This block is the SPI mode 0 slave front end of a small serial device that holds a byte-wide memory and a few internal registers. It runs on the chip's system clock and oversamples the chip-select, serial-clock and serial-data pins through a synchronizer chain. It shifts in an 8-bit opcode and then the address and data bytes of that command, most significant bit first. For read commands it shifts the returned byte out on the serial output, MSB first.

Nine opcodes are recognised. Two of them set or clear a write-enable guard. Four are writes: a memory byte, a two-byte configuration word, a two-byte control word, and a lock-partition byte. Three are reads: a memory read, a lock/write-status read, and a status-register read. No write is issued until chip-select is released at a byte boundary. The guard must be set at that point, and the command must have delivered all of its bytes. When the write is issued, the back end sees a one-cycle request on a parallel port. Reads go out as one-cycle requests, and the back end returns the data byte in the following clock cycle. A register-file model of the back ends sits in the bench.

Top module: `spi_cmd_decoder`

## Requirements
- R1: Serial data is taken on the rising edge of the serial clock and returned on its falling edge (mode 0). Every opcode, address and data byte travels MSB first. The first rising edge after chip-select falls carries opcode bit 7.
- R2: Opcode 0x06 sets the write-enable guard and opcode 0x04 clears it. Either takes effect when chip-select rises. Each write listed in R3 to R5 is issued only while the guard is set.
- R3: Opcode 0x02 is a memory write. It is followed by ADDR_BYTES address bytes (high byte first; the address is their low ADDR_W bits) and a data byte. When chip-select rises, it pulses wr_valid for one cycle with wr_kind 0, wr_addr set to the address, and wr_data[7:0] set to the data byte. It then clears the guard.
- R4: Opcode 0x09 (configuration, wr_kind 1) and opcode 0x0A (control, wr_kind 2) each take two data bytes. The first byte lands in wr_data[15:8] and the second in wr_data[7:0]. These writes leave the guard set.
- R5: Opcode 0x01 sets the lock partition with wr_kind 3 and one data byte in wr_data[7:0]. If more bytes follow, the last one wins. Issuing this write clears the guard.
- R6: A write command sent while the guard is clear produces no request.
- R7: Opcode 0x03 is a memory read. After the last address byte it pulses rd_valid with rd_kind 0 and rd_addr set to the address. The byte on rd_data one cycle later is shifted out on so. Each further byte clocked within the same frame reads the next address.
- R8: Opcode 0x05 reads lock/write status (rd_kind 1) and opcode 0x0B reads the status register (rd_kind 2). The request is made right after the opcode, and the returned byte is shifted out. It is re-read for every further byte.
- R9: An unrecognised opcode causes no request and leaves the guard unchanged. Any bytes after it in the same frame are ignored.
- R10: If chip-select rises after a bit count that is not a multiple of eight, the partial byte is dropped. No write is issued and the guard is left unchanged.
- R11: so_oe is high only while chip-select is low and read data is being shifted out. It is low in reset, during opcode and address bytes, and after chip-select rises.
- R12: The serial clock may stop while chip-select is low. Shifting resumes at the same bit.
- R13: A write command whose data bytes are incomplete when chip-select rises at a byte boundary issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idles low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output-enable for so (low means high impedance) |
| wr_valid | output | 1 | One-cycle write request |
| wr_kind | output | 2 | 0 memory, 1 configuration, 2 control, 3 lock |
| wr_addr | output | ADDR_W | Memory write address |
| wr_data | output | 16 | Write data |
| rd_valid | output | 1 | One-cycle read request |
| rd_kind | output | 2 | 0 memory, 1 lock/write status, 2 status register |
| rd_addr | output | ADDR_W | Memory read address |
| rd_data | input | 8 | Read response, valid the cycle after rd_valid |

## Verification
The bench uses ADDR_W = 9 and SYNC_STAGES = 2, with a serial half-period of six system clocks. A nine-bit address needs two address bytes, so the high address byte and the byte-count thresholds are exercised. The read test starts at 0x0F3 so that the second streamed address is checked as well. The two-stage chain and the slow serial clock leave the read response just enough margin ahead of the first falling edge.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

   typedef enum logic [3:0] {
      CMD_NONE, CMD_WREN, CMD_WRDI, CMD_MEMWR, CMD_MEMRD,
      CMD_LKST, CMD_CFGWR, CMD_CTLWR, CMD_STRD, CMD_LOCK
   } cmd_e;

   typedef enum logic [2:0] {
      PH_OPC, PH_ADDR, PH_DATA, PH_READ, PH_HOLD
   } phase_e;

   localparam logic [1:0] WK_MEM  = 2'd0;
   localparam logic [1:0] WK_CFG  = 2'd1;
   localparam logic [1:0] WK_CTL  = 2'd2;
   localparam logic [1:0] WK_LOCK = 2'd3;

   localparam logic [1:0] RK_MEM  = 2'd0;
   localparam logic [1:0] RK_LKST = 2'd1;
   localparam logic [1:0] RK_STAT = 2'd2;

   function automatic cmd_e decode_op(input logic [7:0] op);
      case (op)
         8'h06:   return CMD_WREN;
         8'h04:   return CMD_WRDI;
         8'h02:   return CMD_MEMWR;
         8'h03:   return CMD_MEMRD;
         8'h05:   return CMD_LKST;
         8'h09:   return CMD_CFGWR;
         8'h0A:   return CMD_CTLWR;
         8'h0B:   return CMD_STRD;
         8'h01:   return CMD_LOCK;
         default: return CMD_NONE;
      endcase
   endfunction

endpackage

// File: rtl/spi_pin_front.sv
module spi_pin_front #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sck,
   input  logic si,
   output logic cs_hi,
   output logic cs_rise,
   output logic sck_rise,
   output logic sck_fall,
   output logic si_s
);
   localparam logic [2:0] PIN_RST = 3'b100;

   logic [2:0] pins;
   assign pins = {cs_n, sck, si};

   for (genvar g = 0; g < STAGES; g++) begin : g_stg
      logic [2:0] q;
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) q <= PIN_RST;
            else        q <= pins;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) q <= PIN_RST;
            else        q <= g_stg[g-1].q;
      end
   end

   logic [2:0] lvl;
   logic       cs_q, sck_q;
   assign lvl = g_stg[STAGES-1].q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         cs_q  <= 1'b1;
         sck_q <= 1'b0;
      end else begin
         cs_q  <= lvl[2];
         sck_q <= lvl[1];
      end

   assign cs_hi    = lvl[2];
   assign cs_rise  = lvl[2] & ~cs_q;
   assign sck_rise = lvl[1] & ~sck_q;
   assign sck_fall = ~lvl[1] & sck_q;
   assign si_s     = lvl[0];
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
   import spi_cmd_pkg::*;
#(
   parameter int ADDR_W     = 9,
   parameter int ADDR_BYTES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_hi,
   input  logic              cs_rise,
   input  logic              sck_rise,
   input  logic              si_s,
   output logic              wr_valid,
   output logic [1:0]        wr_kind,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [15:0]       wr_data,
   output logic              rd_valid,
   output logic [1:0]        rd_kind,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              rd_phase,
   output logic              we_latch
);
   localparam logic [3:0] ADDR_LAST  = 4'(ADDR_BYTES);
   localparam logic [3:0] MEMWR_NEED = 4'(ADDR_BYTES + 2);
   localparam logic [3:0] REG_NEED   = 4'd3;
   localparam logic [3:0] LOCK_NEED  = 4'd2;

   phase_e            ph;
   cmd_e              cmd, op_cmd;
   logic [2:0]        bit_cnt;
   logic [3:0]        byte_cnt;
   logic [6:0]        in_sh;
   logic [ADDR_W-1:0] addr_acc, addr_shift, addr_inc;
   logic [15:0]       data_sh;
   logic [7:0]        new_byte;
   logic              byte_done;

   assign new_byte   = {in_sh, si_s};
   assign byte_done  = (bit_cnt == 3'd7);
   assign op_cmd     = decode_op(new_byte);
   assign addr_shift = ADDR_W'({addr_acc, new_byte});
   assign addr_inc   = addr_acc + ADDR_W'(1);
   assign rd_phase   = (ph == PH_READ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph       <= PH_OPC;
         cmd      <= CMD_NONE;
         bit_cnt  <= '0;
         byte_cnt <= '0;
         in_sh    <= '0;
         addr_acc <= '0;
         data_sh  <= '0;
         we_latch <= 1'b0;
         wr_valid <= 1'b0;
         wr_kind  <= WK_MEM;
         wr_addr  <= '0;
         wr_data  <= '0;
         rd_valid <= 1'b0;
         rd_kind  <= RK_MEM;
         rd_addr  <= '0;
      end else begin
         wr_valid <= 1'b0;
         rd_valid <= 1'b0;
         if (cs_rise) begin
            if (bit_cnt == 3'd0) begin
               case (cmd)
                  CMD_WREN: we_latch <= 1'b1;
                  CMD_WRDI: we_latch <= 1'b0;
                  CMD_MEMWR:
                     if (we_latch && byte_cnt >= MEMWR_NEED) begin
                        wr_valid <= 1'b1;
                        wr_kind  <= WK_MEM;
                        wr_addr  <= addr_acc;
                        wr_data  <= data_sh;
                        we_latch <= 1'b0;
                     end
                  CMD_CFGWR, CMD_CTLWR:
                     if (we_latch && byte_cnt >= REG_NEED) begin
                        wr_valid <= 1'b1;
                        wr_kind  <= (cmd == CMD_CFGWR) ? WK_CFG : WK_CTL;
                        wr_addr  <= '0;
                        wr_data  <= data_sh;
                     end
                  CMD_LOCK:
                     if (we_latch && byte_cnt >= LOCK_NEED) begin
                        wr_valid <= 1'b1;
                        wr_kind  <= WK_LOCK;
                        wr_addr  <= '0;
                        wr_data  <= data_sh;
                        we_latch <= 1'b0;
                     end
                  default: ;
               endcase
            end
         end else if (cs_hi) begin
            ph       <= PH_OPC;
            cmd      <= CMD_NONE;
            bit_cnt  <= '0;
            byte_cnt <= '0;
            addr_acc <= '0;
            data_sh  <= '0;
         end else if (sck_rise) begin
            bit_cnt <= bit_cnt + 3'd1;
            in_sh   <= new_byte[6:0];
            if (byte_done) begin
               if (byte_cnt != 4'hF) byte_cnt <= byte_cnt + 4'd1;
               case (ph)
                  PH_OPC: begin
                     cmd <= op_cmd;
                     case (op_cmd)
                        CMD_MEMWR, CMD_MEMRD: ph <= PH_ADDR;
                        CMD_LKST, CMD_STRD: begin
                           ph       <= PH_READ;
                           rd_valid <= 1'b1;
                           rd_kind  <= (op_cmd == CMD_LKST) ? RK_LKST : RK_STAT;
                           rd_addr  <= addr_acc;
                        end
                        CMD_CFGWR, CMD_CTLWR, CMD_LOCK: ph <= PH_DATA;
                        default: ph <= PH_HOLD;
                     endcase
                  end
                  PH_ADDR: begin
                     addr_acc <= addr_shift;
                     if (byte_cnt == ADDR_LAST) begin
                        if (cmd == CMD_MEMRD) begin
                           ph       <= PH_READ;
                           rd_valid <= 1'b1;
                           rd_kind  <= RK_MEM;
                           rd_addr  <= addr_shift;
                        end else begin
                           ph <= PH_DATA;
                        end
                     end
                  end
                  PH_DATA: data_sh <= {data_sh[7:0], new_byte};
                  PH_READ: begin
                     addr_acc <= addr_inc;
                     rd_valid <= 1'b1;
                     rd_addr  <= addr_inc;
                  end
                  default: ;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/spi_out_shift.sv
module spi_out_shift (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_hi,
   input  logic       sck_fall,
   input  logic       rd_phase,
   input  logic       rd_valid,
   input  logic [7:0] rd_data,
   output logic       so,
   output logic       so_oe
);
   logic [7:0] sh;
   logic       load_pend, loaded;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh        <= '0;
         load_pend <= 1'b0;
         loaded    <= 1'b0;
         so        <= 1'b0;
         so_oe     <= 1'b0;
      end else if (cs_hi) begin
         load_pend <= 1'b0;
         loaded    <= 1'b0;
         so        <= 1'b0;
         so_oe     <= 1'b0;
      end else begin
         load_pend <= rd_valid;
         if (load_pend) begin
            sh     <= rd_data;
            loaded <= 1'b1;
         end else if (sck_fall && rd_phase && loaded) begin
            so    <= sh[7];
            sh    <= {sh[6:0], 1'b0};
            so_oe <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder #(
   parameter int ADDR_W      = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sck,
   input  logic              si,
   output logic              so,
   output logic              so_oe,
   output logic              wr_valid,
   output logic [1:0]        wr_kind,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [15:0]       wr_data,
   output logic              rd_valid,
   output logic [1:0]        rd_kind,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [7:0]        rd_data
);
   localparam int ADDR_BYTES = (ADDR_W + 7) / 8;

   initial begin
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert (ADDR_W >= 1 && ADDR_W <= 32) else $error("ADDR_W out of range");
   end

   logic cs_hi, cs_rise, sck_rise, sck_fall, si_s;
   logic rd_phase, we_latch;

   spi_pin_front #(.STAGES(SYNC_STAGES)) u_front (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
      .cs_hi(cs_hi), .cs_rise(cs_rise), .sck_rise(sck_rise),
      .sck_fall(sck_fall), .si_s(si_s)
   );

   spi_cmd_engine #(.ADDR_W(ADDR_W), .ADDR_BYTES(ADDR_BYTES)) u_engine (
      .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .cs_rise(cs_rise),
      .sck_rise(sck_rise), .si_s(si_s),
      .wr_valid(wr_valid), .wr_kind(wr_kind), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_valid(rd_valid), .rd_kind(rd_kind),
      .rd_addr(rd_addr), .rd_phase(rd_phase), .we_latch(we_latch)
   );

   spi_out_shift u_out (
      .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .sck_fall(sck_fall),
      .rd_phase(rd_phase), .rd_valid(rd_valid), .rd_data(rd_data),
      .so(so), .so_oe(so_oe)
   );
endmodule

// File: rtl/spi_cmd_decoder_chk.sv
module spi_cmd_decoder_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_hi,
   input logic       sck_fall,
   input logic       wr_valid,
   input logic [1:0] wr_kind,
   input logic       rd_valid,
   input logic       so,
   input logic       so_oe,
   input logic       we_latch
);
   // R2 / R6: an issued write always had the guard set beforehand
   p_write_needs_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> $past(we_latch));

   // R3 / R5: memory and lock writes leave the guard cleared
   p_guard_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && (wr_kind == 2'd0 || wr_kind == 2'd3)) |-> !we_latch);

   // R10: writes are issued only when chip-select has been released
   p_commit_on_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> $past(cs_hi));

   // R3: write requests last one cycle
   p_wr_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> !wr_valid);

   // R7: read requests last one cycle and never coincide with a write
   p_rd_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);
   p_rd_wr_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_valid && wr_valid));

   // R11: output enable drops once chip-select is high
   p_oe_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cs_hi |=> !so_oe);

   // R1: serial output moves only after a falling clock edge or on release
   p_so_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(so) |-> ($past(sck_fall) || $past(cs_hi)));
endmodule

bind spi_cmd_decoder spi_cmd_decoder_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .sck_fall(sck_fall),
   .wr_valid(wr_valid), .wr_kind(wr_kind), .rd_valid(rd_valid),
   .so(so), .so_oe(so_oe), .we_latch(we_latch)
);

// File: tb/spi_cmd_decoder_bench.sv
module spi_cmd_decoder_bench;
   localparam int AW   = 9;
   localparam int HALF = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n = 1'b1, sck = 1'b0, si = 1'b0;
   logic          so, so_oe, wr_valid, rd_valid;
   logic [1:0]    wr_kind, rd_kind;
   logic [AW-1:0] wr_addr, rd_addr;
   logic [15:0]   wr_data;
   logic [7:0]    rd_data = 8'h00;

   int n_chk = 0, n_err = 0;
   int wr_cnt = 0, rd_cnt = 0;
   logic [1:0]    last_wk, last_rk;
   logic [AW-1:0] last_wa;
   logic [AW-1:0] rd_log [0:7];
   logic [15:0]   last_wd;
   bit done = 1'b0;

   always #4 clk = ~clk;

   spi_cmd_decoder #(.ADDR_W(AW), .SYNC_STAGES(2)) u_spi_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
      .so(so), .so_oe(so_oe), .wr_valid(wr_valid), .wr_kind(wr_kind),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_valid(rd_valid),
      .rd_kind(rd_kind), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   function automatic logic [7:0] mem_val(input logic [AW-1:0] a);
      return a[7:0] ^ 8'h5A;
   endfunction

   // back-end model: registered response, recorded requests
   always @(posedge clk) begin
      if (wr_valid) begin
         wr_cnt  <= wr_cnt + 1;
         last_wk <= wr_kind;
         last_wa <= wr_addr;
         last_wd <= wr_data;
      end
      if (rd_valid) begin
         rd_log[rd_cnt % 8] <= rd_addr;
         rd_cnt  <= rd_cnt + 1;
         last_rk <= rd_kind;
         case (rd_kind)
            2'd0:    rd_data <= mem_val(rd_addr);
            2'd1:    rd_data <= 8'h3C;
            default: rd_data <= 8'hC7;
         endcase
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic half();
      repeat (HALF) @(negedge clk);
   endtask

   task automatic xfer(input logic [7:0] tx, input int nbits, input int pause_at,
                       output logic [7:0] rx, output logic oe_any);
      rx = '0;
      oe_any = 1'b0;
      for (int i = 7; i >= 8 - nbits; i--) begin
         si = tx[i];
         if (i == pause_at) repeat (100) @(negedge clk);
         half();
         rx[i] = so;
         oe_any = oe_any | so_oe;
         sck = 1'b1;
         half();
         sck = 1'b0;
      end
   endtask

   task automatic tx_byte(input logic [7:0] b);
      logic [7:0] r;
      logic o;
      xfer(b, 8, -1, r, o);
   endtask

   task automatic begin_frame();
      cs_n = 1'b0;
   endtask

   task automatic end_frame();
      half();
      cs_n = 1'b1;
      repeat (4 * HALF) @(negedge clk);
   endtask

   task automatic one_op(input logic [7:0] b);
      begin_frame(); tx_byte(b); end_frame();
   endtask

   task automatic mem_write(input logic [AW-1:0] a, input logic [7:0] d);
      logic [15:0] aw;
      aw = 16'(a);
      begin_frame();
      tx_byte(8'h02); tx_byte(aw[15:8]); tx_byte(aw[7:0]); tx_byte(d);
      end_frame();
   endtask

   task automatic t_reset();
      chk("R11 so_oe in reset", int'(so_oe), 0);
      chk("R6 no write in reset", wr_cnt, 0);
   endtask

   task automatic t_no_guard();
      int c0 = wr_cnt;
      mem_write(9'h055, 8'h11);
      chk("R6 write without guard", wr_cnt - c0, 0);
   endtask

   task automatic t_mem_write();
      int c0;
      one_op(8'h06);
      c0 = wr_cnt;
      mem_write(9'h1A5, 8'h5C);
      chk("R3 write count", wr_cnt - c0, 1);
      chk("R3 kind", int'(last_wk), 0);
      chk("R3 address", int'(last_wa), 'h1A5);
      chk("R1 R3 data byte", int'(last_wd[7:0]), 'h5C);
      c0 = wr_cnt;
      mem_write(9'h1A6, 8'h77);
      chk("R3 guard cleared after write", wr_cnt - c0, 0);
   endtask

   task automatic t_regs();
      int c0;
      one_op(8'h06);
      c0 = wr_cnt;
      begin_frame(); tx_byte(8'h09); tx_byte(8'h12); tx_byte(8'h34); end_frame();
      chk("R4 config count", wr_cnt - c0, 1);
      chk("R4 config kind", int'(last_wk), 1);
      chk("R4 config data", int'(last_wd), 'h1234);
      begin_frame(); tx_byte(8'h0A); tx_byte(8'hAB); tx_byte(8'hCD); end_frame();
      chk("R4 control kept guard", wr_cnt - c0, 2);
      chk("R4 control kind", int'(last_wk), 2);
      chk("R4 control data", int'(last_wd), 'hABCD);
      one_op(8'h04);
      c0 = wr_cnt;
      begin_frame(); tx_byte(8'h09); tx_byte(8'h01); tx_byte(8'h02); end_frame();
      chk("R2 clear opcode blocks write", wr_cnt - c0, 0);
   endtask

   task automatic t_lock();
      int c0;
      one_op(8'h06);
      c0 = wr_cnt;
      begin_frame(); tx_byte(8'h01); tx_byte(8'h03); tx_byte(8'h06); end_frame();
      chk("R5 lock count", wr_cnt - c0, 1);
      chk("R5 lock kind", int'(last_wk), 3);
      chk("R5 last byte wins", int'(last_wd[7:0]), 'h06);
      c0 = wr_cnt;
      begin_frame(); tx_byte(8'h01); tx_byte(8'h02); end_frame();
      chk("R5 guard cleared after lock", wr_cnt - c0, 0);
   endtask

   task automatic t_mem_read();
      logic [7:0] r;
      logic o;
      int c0 = rd_cnt;
      begin_frame();
      xfer(8'h03, 8, -1, r, o);
      chk("R11 oe low in opcode", int'(o), 0);
      xfer(8'h00, 8, -1, r, o);
      xfer(8'hF3, 8, -1, r, o);
      chk("R11 oe low in address", int'(o), 0);
      xfer(8'h00, 8, -1, r, o);
      chk("R7 R1 first read byte", int'(r), int'(mem_val(9'h0F3)));
      chk("R11 oe high in read", int'(o), 1);
      xfer(8'h00, 8, -1, r, o);
      chk("R7 streamed byte", int'(r), int'(mem_val(9'h0F4)));
      end_frame();
      chk("R7 read requests", rd_cnt - c0, 3);
      chk("R7 read address", int'(rd_log[c0 % 8]), 'h0F3);
      chk("R7 read kind", int'(last_rk), 0);
      chk("R11 oe low after release", int'(so_oe), 0);
   endtask

   task automatic t_status();
      logic [7:0] r;
      logic o;
      begin_frame();
      xfer(8'h0B, 8, -1, r, o);
      xfer(8'h00, 8, -1, r, o);
      chk("R8 status byte", int'(r), 'hC7);
      xfer(8'h00, 8, -1, r, o);
      chk("R8 status repeat", int'(r), 'hC7);
      end_frame();
      chk("R8 status kind", int'(last_rk), 2);
      begin_frame();
      xfer(8'h05, 8, -1, r, o);
      xfer(8'h00, 8, -1, r, o);
      end_frame();
      chk("R8 lock status byte", int'(r), 'h3C);
      chk("R8 lock status kind", int'(last_rk), 1);
   endtask

   task automatic t_bad_op();
      int c0, r0;
      one_op(8'h06);
      c0 = wr_cnt;
      r0 = rd_cnt;
      begin_frame();
      tx_byte(8'h77); tx_byte(8'h02); tx_byte(8'h00); tx_byte(8'h10); tx_byte(8'h55);
      end_frame();
      chk("R9 no write after bad opcode", wr_cnt - c0, 0);
      chk("R9 no read after bad opcode", rd_cnt - r0, 0);
      mem_write(9'h010, 8'h99);
      chk("R9 guard kept", wr_cnt - c0, 1);
   endtask

   task automatic t_partial();
      logic [7:0] r;
      logic o;
      int c0;
      one_op(8'h06);
      c0 = wr_cnt;
      begin_frame();
      tx_byte(8'h02); tx_byte(8'h00); tx_byte(8'h20);
      xfer(8'hF0, 4, -1, r, o);
      end_frame();
      chk("R10 partial byte no write", wr_cnt - c0, 0);
      mem_write(9'h020, 8'h42);
      chk("R10 guard unchanged", wr_cnt - c0, 1);
      chk("R10 later write data", int'(last_wd[7:0]), 'h42);
   endtask

   task automatic t_short();
      int c0;
      one_op(8'h06);
      c0 = wr_cnt;
      begin_frame(); tx_byte(8'h09); tx_byte(8'h5A); end_frame();
      chk("R13 short config no write", wr_cnt - c0, 0);
      one_op(8'h04);
   endtask

   task automatic t_pause();
      logic [7:0] r;
      logic o;
      int c0;
      one_op(8'h06);
      c0 = wr_cnt;
      begin_frame();
      tx_byte(8'h02); tx_byte(8'h01);
      xfer(8'h3C, 8, 4, r, o);
      xfer(8'hE1, 8, 2, r, o);
      end_frame();
      chk("R12 paused write count", wr_cnt - c0, 1);
      chk("R12 paused address", int'(last_wa), 'h13C);
      chk("R12 paused data", int'(last_wd[7:0]), 'hE1);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_no_guard();
      t_mem_write();
      t_regs();
      t_lock();
      t_mem_read();
      t_status();
      t_bad_op();
      t_partial();
      t_short();
      t_pause();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end
endmodule